// File: doc/BRIEF.md
# Dual-Action Count-Up Watchdog

This block holds two independent supervision timers behind one small register port. Each timer counts upward by one on a shared periodic tick, which a prescaler derives from the core clock so that one count stands for 10 ms of elapsed time. Software arms a timer by writing its register with a limit and an action-enable bit. Any write to a timer's register also restarts that timer's count from zero, so firmware services the watchdog by rewriting the register before the count reaches the limit.

Timer 0 drives a system reset request. Timer 1 drives a protective-mode flag. Logic further downstream uses that flag to discard all traffic bound for the host processor and to turn off flow control on every port. When a timer's count reaches its limit, the count stops there and the action output stays asserted until the next write to that timer. A limit of zero disarms the timer, so a freshly reset part never fires.

Each register word has the same layout. Bit 31 is the action enable. Bits 30:16 are the limit. Bit 15 is reserved and reads zero. Bits 14:0 hold the live count, which is read-only. Software decodes these positions, so they are fixed.

Top module: `wdt_pair`

## Requirements
- R1: After reset, both register words read 0x00000000, and `sys_reset_req` and `guard_mode` are 0.
- R2: A write stores bit 31 as the action enable and bits 30:16 as the limit. Written values in bits 15:0 are discarded. Bit 15 always reads 0, and bits 14:0 read back the live count.
- R3: A write to one timer (`reg_sel` 0 or 1) clears that timer's count to 0 and drops its action output from the next cycle on. The other timer is not affected.
- R4: While armed and below its limit, a timer's count rises by exactly one per tick. A tick occurs once every `TICK_DIV` clock cycles from a free-running prescaler, which writes do not restart. Any window of 40 clocks therefore holds 10 ticks when `TICK_DIV` = 4.
- R5: A count that equals the limit holds at the limit and never wraps.
- R6: With a limit of 0, the count stays at 0 and no action fires, whatever the enable bit holds.
- R7: `sys_reset_req` is 1 exactly when timer 0 has enable = 1, a nonzero limit, and a count equal to that limit. Once set, it stays set until timer 0 is written.
- R8: If timer 0's enable bit is 0, `sys_reset_req` stays 0, even when the count has reached the limit.
- R9: `guard_mode` follows the rule of R7 for timer 1. It stays 0 while timer 1's enable bit is 0.
- R10: If a write and a tick land in the same cycle, the write wins and the count reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected timer register |
| reg_sel | input | 1 | Timer select: 0 = reset timer, 1 = protective-mode timer |
| reg_wdata | input | 32 | Write data (bit 31 enable, bits 30:16 limit) |
| reg_rdata | output | 32 | Read data of the selected timer (combinational) |
| sys_reset_req | output | 1 | System reset request from timer 0 |
| guard_mode | output | 1 | Protective-mode flag from timer 1 |

## Verification
The checker tests several properties on every cycle, judging each from the port view. Bit 15 always reads zero. The count never passes a nonzero limit and stays at zero when the limit is zero. The count moves by at most one between cycles. A write clears the selected count and drops its action. Both action flags are sticky until their timer is written. Timer 0 never requests a reset while its enable reads zero. Other behaviours can only be shown by the bench's scenarios against its cycle model: the exact tick rate, a write winning over a coincident tick, independence between the two timers, and the fact that written count bits are discarded.

// File: rtl/wdt_pair_pkg.sv
package wdt_pair_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned FIELD_W = 15;

   // Register word as seen by software; positions are decoded by drivers.
   typedef struct packed {
      logic               act_en;   // [31]
      logic [FIELD_W-1:0] limit;    // [30:16]
      logic               spare;    // [15] reads zero
      logic [FIELD_W-1:0] count;    // [14:0] live count, read-only
   } wdt_word_t;

   localparam int unsigned IDX_RESET = 0;
   localparam int unsigned IDX_GUARD = 1;
   localparam int unsigned NUM_TMR   = 2;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int unsigned DIV = 1_250_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pair_pkg::*;
#(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_limit,
   output wdt_word_t        view,
   output logic             fire
);
   logic             en_q;
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed;
   logic             at_limit;

   assign armed    = (limit_q != '0);
   assign at_limit = (cnt_q == limit_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         limit_q <= '0;
         cnt_q   <= '0;
      end else if (load) begin
         // service write: reconfigure and restart, wins over a tick
         en_q    <= load_en;
         limit_q <= load_limit;
         cnt_q   <= '0;
      end else if (tick && armed && !at_limit) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign fire = en_q & armed & at_limit;

   always_comb begin
      view                    = '0;
      view.act_en             = en_q;
      view.limit[CNT_W-1:0]   = limit_q;
      view.count[CNT_W-1:0]   = cnt_q;
   end
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux
   import wdt_pair_pkg::*;
(
   input  logic                    sel,
   input  wdt_word_t [NUM_TMR-1:0] words,
   output logic [WORD_W-1:0]       rdata
);
   always_comb begin
      rdata = words[sel];
   end
endmodule

// File: rtl/wdt_pair.sv
module wdt_pair
   import wdt_pair_pkg::*;
#(
   parameter int unsigned TICK_DIV = 1_250_000,
   parameter int unsigned CNT_W    = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        sys_reset_req,
   output logic        guard_mode
);
   localparam int unsigned LIM_LSB = FIELD_W + 1;
   localparam int unsigned EN_BIT  = WORD_W - 1;

   if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_width
      $error("wdt_pair: CNT_W must lie in 1..15");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("wdt_pair: TICK_DIV must be at least 2");
   end

   logic                    tick;
   wdt_word_t [NUM_TMR-1:0] views;
   logic [NUM_TMR-1:0]      fires;
   logic                    unused_wbits;

   assign unused_wbits = ^reg_wdata;

   wdt_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      wdt_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .load       (reg_wr && (reg_sel == 1'(t))),
         .load_en    (reg_wdata[EN_BIT]),
         .load_limit (reg_wdata[LIM_LSB +: CNT_W]),
         .view       (views[t]),
         .fire       (fires[t])
      );
   end

   wdt_rd_mux u_rd (
      .sel   (reg_sel),
      .words (views),
      .rdata (reg_rdata)
   );

   assign sys_reset_req = fires[IDX_RESET];
   assign guard_mode    = fires[IDX_GUARD];
endmodule

// File: rtl/wdt_pair_chk.sv
module wdt_pair_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_sel,
   input logic [31:0] reg_rdata,
   input logic        sys_reset_req,
   input logic        guard_mode
);
   p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[15] == 1'b0);

   p_wr_clear0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel) |=> (reg_sel || (reg_rdata[14:0] == 15'd0 && !sys_reset_req)));

   p_wr_clear1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel) |=> (!reg_sel || (reg_rdata[14:0] == 15'd0 && !guard_mode)));

   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_wr) && $stable(reg_sel)) |->
      (reg_rdata[14:0] == $past(reg_rdata[14:0]) ||
       reg_rdata[14:0] == $past(reg_rdata[14:0]) + 15'd1));

   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[30:16] != 15'd0) |-> (reg_rdata[14:0] <= reg_rdata[30:16]));

   p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[30:16] == 15'd0) |-> (reg_rdata[14:0] == 15'd0));

   p_reset_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_reset_req && !(reg_wr && !reg_sel)) |=> sys_reset_req);

   p_reset_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_sel && !reg_rdata[31]) |-> !sys_reset_req);

   p_guard_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_mode && !(reg_wr && reg_sel)) |=> guard_mode);
endmodule

bind wdt_pair wdt_pair_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_sel       (reg_sel),
   .reg_rdata     (reg_rdata),
   .sys_reset_req (sys_reset_req),
   .guard_mode    (guard_mode)
);

// File: tb/wdt_pair_tb_top.sv
`timescale 1ns/1ps
module wdt_pair_tb_top;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sys_reset_req;
   logic        guard_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   wdt_pair #(.TICK_DIV(DIV), .CNT_W(15)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sys_reset_req(sys_reset_req), .guard_mode(guard_mode)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_pc = 0;
   int m_cnt [2] = '{0, 0};
   int m_th  [2] = '{0, 0};
   bit m_en  [2] = '{0, 0};

   always @(posedge clk or negedge rst_n) begin : mdl
      bit tk;
      if (!rst_n) begin
         m_pc = 0;
         for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_th[c] = 0; m_en[c] = 0; end
      end else begin
         tk = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         for (int c = 0; c < 2; c++) begin
            if (reg_wr && reg_sel == c[0]) begin
               m_en[c]  = reg_wdata[31];
               m_th[c]  = int'(reg_wdata[30:16]);
               m_cnt[c] = 0;
            end else if (tk && m_th[c] != 0 && m_cnt[c] < m_th[c]) begin
               m_cnt[c] = m_cnt[c] + 1;
            end
         end
      end
   end

   function automatic bit exp_act(input int c);
      return m_en[c] && m_th[c] != 0 && m_cnt[c] == m_th[c];
   endfunction

   // per-cycle comparison against the model
   always begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
         chk(reg_rdata[14:0] == 15'(m_cnt[reg_sel]), "R4 live count vs model",
             reg_rdata[14:0], m_cnt[reg_sel]);
         chk(reg_rdata[31:15] == {m_en[reg_sel], 15'(m_th[reg_sel]), 1'b0}, "R2 config field vs model",
             reg_rdata[31:15], {m_en[reg_sel], 15'(m_th[reg_sel]), 1'b0});
         chk(sys_reset_req == exp_act(0), "R7 reset request vs model", sys_reset_req, exp_act(0));
         chk(guard_mode == exp_act(1), "R9 guard flag vs model", guard_mode, exp_act(1));
      end
   end

   task automatic wr(input bit sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk);
      #2;
      reg_wr = 1'b0;
   endtask

   task automatic wr_on_tick(input bit sel, input logic [31:0] d);
      @(negedge clk);
      while (m_pc != DIV - 1) @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk);
      #2;
      reg_wr = 1'b0;
   endtask

   task automatic look(input bit sel);
      @(negedge clk);
      reg_sel = sel;
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   function automatic logic [31:0] word(input bit en, input int lim);
      return {en, 15'(lim), 16'h0000};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(reg_rdata == 32'h0, "R1 timer0 word after reset", reg_rdata, 0);
      chk(!sys_reset_req && !guard_mode, "R1 outputs after reset", {sys_reset_req, guard_mode}, 0);
      reg_sel = 1'b1;
      #1;
      chk(reg_rdata == 32'h0, "R1 timer1 word after reset", reg_rdata, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: disarmed after reset, nothing counts
      idle(40);
      chk(reg_rdata[14:0] == 0, "R6 timer1 count with zero limit", reg_rdata[14:0], 0);
      look(0);
      chk(reg_rdata[14:0] == 0 && !sys_reset_req, "R6 timer0 idle with zero limit", reg_rdata, 0);

      // arm timer1 with a long limit
      wr(1, word(1, 200));

      // R2: count bits discarded, spare reads zero
      wr(0, 32'hFFFF_FFFF);
      chk(reg_rdata == 32'hFFFF_0000, "R2 readback of all-ones write", reg_rdata, 32'hFFFF_0000);

      // R5 / R7: saturate and request reset
      wr(0, word(1, 5));
      idle(40);
      chk(reg_rdata[14:0] == 15'd5, "R5 count holds at limit", reg_rdata[14:0], 5);
      chk(sys_reset_req == 1'b1, "R7 reset request at limit", sys_reset_req, 1);
      chk(guard_mode == 1'b0, "R9 guard quiet below limit", guard_mode, 0);

      // R3: service write clears count and request
      wr(0, word(0, 1000));
      chk(reg_rdata[14:0] == 0 && !sys_reset_req, "R3 write clears count and request",
          {sys_reset_req, reg_rdata[14:0]}, 0);

      // R4: 40 clocks hold exactly 10 ticks
      idle(40);
      chk(reg_rdata[14:0] == 15'd10, "R4 ten ticks in forty clocks", reg_rdata[14:0], 10);
      look(1);
      chk(reg_rdata[14:0] == 15'(m_cnt[1]) && m_cnt[1] > 20, "R3 other timer unaffected",
          reg_rdata[14:0], m_cnt[1]);

      // R8: disabled timer reaches limit without reset
      wr(0, word(0, 3));
      idle(20);
      chk(reg_rdata[14:0] == 15'd3, "R8 disabled timer reaches limit", reg_rdata[14:0], 3);
      chk(sys_reset_req == 1'b0, "R8 no reset while disabled", sys_reset_req, 1'b0);

      // R10: write coincident with a tick
      wr(0, word(0, 50));
      idle(10);
      wr_on_tick(0, word(0, 50));
      chk(reg_rdata[14:0] == 0, "R10 write beats coincident tick", reg_rdata[14:0], 0);

      // R9: protective mode
      wr(1, word(1, 2));
      idle(12);
      chk(guard_mode == 1'b1 && reg_rdata[14:0] == 15'd2, "R9 guard flag at limit",
          {guard_mode, reg_rdata[14:0]}, {1'b1, 15'd2});
      chk(sys_reset_req == 1'b0, "R9 reset output independent", sys_reset_req, 0);
      wr(1, word(0, 2));
      idle(12);
      chk(guard_mode == 1'b0, "R9 guard stays off when disabled", guard_mode, 0);

      // R7: stickiness over a long wait
      wr(0, word(1, 1));
      idle(8);
      chk(sys_reset_req == 1'b1, "R7 reset request set", sys_reset_req, 1);
      idle(30);
      chk(sys_reset_req == 1'b1, "R7 reset request sticky", sys_reset_req, 1);

      // R6: zero limit with enable set
      wr(0, word(1, 0));
      idle(30);
      chk(reg_rdata[14:0] == 0 && !sys_reset_req, "R6 enabled but zero limit",
          {sys_reset_req, reg_rdata[14:0]}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule